// File: doc/BRIEF.md
# First-Come First-Served Bus Arbiter

This block shares one bus among four requesters. Each requester pulls its own active-low request line low to ask for the bus. The block answers on a matching active-low grant line, and it grants in order of arrival rather than by a fixed index rank. Requests may come from other clock domains, so each one passes through a chain of synchronizer flops. Arrival order is then decided on the block's own clock. If several requests become visible in the same clock cycle, the lowest index wins. Requesters that are already waiting are served in the order in which they arrived.

A granted requester keeps the bus until it raises its request line again. The grant is then released for at least one clock before the bus passes to anyone else. A shared active-low enable can force every grant line high. While it does so, arbitration carries on internally. The grant lines come straight from flops, so they change only on clock edges and cannot glitch, even when requests contend. A separate four-input AND gate has no connection to the arbiter. It can combine several request sources into one request, or be used as a free gate.

Top module: `fcfs_arbiter`

## Requirements
- R1: `grant_n[i]` goes low only for requester i, and only while that requester's synchronized request (`req_n[i]` low) is present. Bit i of `grant_n` belongs to bit i of `req_n`.
- R2: At most one bit of `grant_n` is low in any cycle.
- R3: A request that was synchronized in an earlier cycle is granted before a request synchronized in a later cycle, whatever their indices.
- R4: When several requests are first synchronized in the same cycle, the one with the lowest index is granted first.
- R5: A grant is held for as long as the request stays low. After the request goes high, `grant_n` is all ones for at least one clock cycle before any other grant appears, and the grant never moves directly from one requester to another.
- R6: While `en_n` is high at a clock edge, `grant_n` is all ones after that edge. Arbitration continues meanwhile, so when `en_n` returns low the current owner's grant reappears on the next edge.
- R7: A request line held permanently high is never granted and does not affect the order among the other requesters.
- R8: With the bus idle, a `req_n` bit that goes low before a clock edge produces a low grant after the fourth rising edge, and not before.
- R9: `and_out` is the logical AND of the four bits of `and_in`, independent of the clock and of the arbiter.
- R10: A synchronous reset (`rst_n` low at a clock edge) drives `grant_n` to all ones and clears the arrival record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 4 | Bus requests, one per requester, active low, may be asynchronous |
| en_n | input | 1 | Common grant enable, active low |
| and_in | input | 4 | Inputs of the helper AND gate |
| grant_n | output | 4 | Bus grants, one per requester, active low, registered |
| and_out | output | 1 | Output of the helper AND gate |

## Verification
Directed sequences check four things separately: the latency from an idle bus; a later arrival on a low index waiting behind an earlier arrival on a high index, which separates arrival order from index priority; two requests arriving in the same cycle, which exercises the tie-break; and the enable being pulsed while a grant is held. Constrained random traffic then toggles all four requests together with occasional enable drops and a reset in mid-run. The result is compared every cycle against a timestamp-based model in the bench, so that withdrawals while waiting, re-arrivals and release gaps are covered. A second random phase ties one request high to confirm that it is ignored. The AND helper is checked against random input values.

// File: rtl/fcfs_pkg.sv
package fcfs_pkg;
  localparam int FCFS_PORTS = 4;
  localparam int FCFS_SYNC_DEPTH = 2;

  // keep only the lowest set bit of a vector (up to 32 wide)
  function automatic logic [31:0] lowest_onehot(logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/fcfs_sync.sv
module fcfs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/fcfs_order.sv
module fcfs_order #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] want,
  output logic [N-1:0] arrive,
  output logic [N-1:0] queued,
  output logic [N-1:0] oldest
);
  import fcfs_pkg::*;

  logic [N-1:0] want_d;
  // before_q[a][b] = 1 : requester a arrived ahead of requester b
  logic [N-1:0] before_q [N];
  logic [N-1:0] blocked;
  logic [31:0]  pick;

  assign arrive = want & ~want_d;
  assign queued = want & want_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_d <= '0;
      for (int a = 0; a < N; a++) before_q[a] <= '0;
    end else begin
      want_d <= want;
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          if (a != b) begin
            if (arrive[b])
              before_q[a][b] <= queued[a] | (arrive[a] && (a < b));
            else if (arrive[a])
              before_q[a][b] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < N; b++) begin
      blocked[b] = 1'b0;
      for (int a = 0; a < N; a++)
        if (a != b && queued[a] && before_q[a][b]) blocked[b] = 1'b1;
    end
  end

  assign pick   = lowest_onehot(32'(queued & ~blocked));
  assign oldest = pick[N-1:0];
endmodule

// File: rtl/fcfs_grant.sv
module fcfs_grant #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  logic [N-1:0] want,
  input  logic [N-1:0] oldest,
  output logic [N-1:0] gnt_q,
  output logic [N-1:0] grant_n
);
  logic [N-1:0] gnt_next;
  logic         owner_keeps;

  assign owner_keeps = (gnt_q & want) != '0;

  always_comb begin
    if (gnt_q != '0) gnt_next = owner_keeps ? gnt_q : '0;
    else             gnt_next = oldest;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q   <= '0;
      grant_n <= '1;
    end else begin
      gnt_q   <= gnt_next;
      grant_n <= ~(gnt_next & {N{~en_n}});
    end
  end
endmodule

// File: rtl/fcfs_arbiter.sv
module fcfs_arbiter
  import fcfs_pkg::*;
#(
  parameter int N_REQ      = FCFS_PORTS,
  parameter int SYNC_DEPTH = FCFS_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_n,
  input  logic             en_n,
  input  logic [N_REQ-1:0] and_in,
  output logic [N_REQ-1:0] grant_n,
  output logic             and_out
);
  logic [N_REQ-1:0] want;
  logic [N_REQ-1:0] arrive;
  logic [N_REQ-1:0] queued;
  logic [N_REQ-1:0] oldest;
  logic [N_REQ-1:0] gnt_q;

  fcfs_sync #(.WIDTH(N_REQ), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (~req_n),
    .sync_out (want)
  );

  fcfs_order #(.N(N_REQ)) u_order (
    .clk    (clk),
    .rst_n  (rst_n),
    .want   (want),
    .arrive (arrive),
    .queued (queued),
    .oldest (oldest)
  );

  fcfs_grant #(.N(N_REQ)) u_grant (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_n    (en_n),
    .want    (want),
    .oldest  (oldest),
    .gnt_q   (gnt_q),
    .grant_n (grant_n)
  );

  assign and_out = &and_in;
endmodule

// File: rtl/fcfs_checker.sv
module fcfs_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_n,
  input logic [N-1:0] grant_n,
  input logic [N-1:0] want,
  input logic [N-1:0] gnt_q
);
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grant_n));

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> (grant_n == '1));

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_n) |-> (grant_n == '1));

  assert_hold_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q & want) != '0) |=> (gnt_q == $past(gnt_q)));

  assert_no_direct_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q != '0) |=> ((gnt_q == $past(gnt_q)) || (gnt_q == '0)));

  assert_grant_to_requester_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_q & ~$past(gnt_q)) != '0) |-> ((gnt_q & $past(want)) == gnt_q));
endmodule

bind fcfs_arbiter fcfs_checker #(.N(N_REQ)) u_fcfs_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_n    (en_n),
  .grant_n (grant_n),
  .want    (want),
  .gnt_q   (gnt_q)
);

// File: tb/fcfs_arbiter_test.sv
`timescale 1ns/1ps
module fcfs_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_n = 1'b1;
  logic [3:0] req_n = 4'hF;
  logic [3:0] and_in = 4'h0;
  logic [3:0] grant_n;
  logic       and_out;

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  bit    r3_tied_phase = 1'b0;
  int    tied_grants = 0;

  // reference model state
  bit [3:0]   m_s1, m_s2, m_wd;
  int         stamp [4];
  int         m_gnt = -1;
  logic [3:0] m_out = 4'hF;
  int         cyc = 0;

  fcfs_arbiter uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (req_n),
    .en_n    (en_n),
    .and_in  (and_in),
    .grant_n (grant_n),
    .and_out (and_out)
  );

  always #2.5 clk = ~clk;

  // the earliest-stamped waiting requester; strict compare keeps the lower index on a tie
  function automatic int first_waiting(bit [3:0] s2, bit [3:0] wd, int st0, int st1, int st2, int st3);
    int best = -1;
    int st [4];
    st[0] = st0; st[1] = st1; st[2] = st2; st[3] = st3;
    for (int i = 0; i < 4; i++)
      if (s2[i] && wd[i] && (best < 0 || st[i] < st[best])) best = i;
    return best;
  endfunction

  always @(posedge clk) begin
    int nxt;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_wd = '0; m_gnt = -1; m_out = 4'hF;
    end else begin
      if (m_gnt >= 0) nxt = m_s2[m_gnt] ? m_gnt : -1;
      else nxt = first_waiting(m_s2, m_wd, stamp[0], stamp[1], stamp[2], stamp[3]);
      for (int i = 0; i < 4; i++) if (m_s2[i] && !m_wd[i]) stamp[i] = cyc;
      m_out = (nxt >= 0 && !en_n) ? ~(4'b0001 << nxt) : 4'hF;
      m_gnt = nxt;
      m_wd = m_s2; m_s2 = m_s1; m_s1 = ~req_n;
    end
    cyc++;
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: grant_n actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(tag, grant_n, m_out);
      checks++;
      if ($countones(~grant_n) > 1) begin
        errors++;
        $display("FAIL R2: grant_n actual %b expected at most one low bit", grant_n);
      end
      if (r3_tied_phase && !grant_n[3]) tied_grants++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung run expected completion (all requirements)");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1705));
    step(3);
    check("R10", grant_n, 4'hF);
    cmp_on = 1'b1;
    en_n = 1'b0;
    rst_n = 1'b1;
    step(2);

    // R8: latency from idle
    tag = "R8";
    req_n[2] = 1'b0;
    step(3);
    check("R8", grant_n, 4'hF);
    step(1);
    check("R8", grant_n, 4'b1011);

    // R3: later low index waits behind earlier high index
    tag = "R3";
    req_n[3] = 1'b0;
    step(2);
    req_n[0] = 1'b0;
    step(3);
    req_n[2] = 1'b1;
    step(3);
    check("R5", grant_n, 4'hF);
    step(1);
    check("R3", grant_n, 4'b0111);

    // R4: same-cycle arrivals
    tag = "R4";
    req_n = 4'hF;
    step(6);
    req_n[3] = 1'b0;
    step(5);
    req_n[2] = 1'b0; req_n[1] = 1'b0;
    step(4);
    req_n[3] = 1'b1;
    step(4);
    check("R4", grant_n, 4'b1101);
    req_n[1] = 1'b1;
    step(4);
    check("R4", grant_n, 4'b1011);

    // R6: enable gating with state kept
    tag = "R6";
    en_n = 1'b1;
    step(1);
    check("R6", grant_n, 4'hF);
    step(3);
    check("R6", grant_n, 4'hF);
    en_n = 1'b0;
    step(1);
    check("R6", grant_n, 4'b1011);

    // R9: helper AND gate
    for (int k = 0; k < 16; k++) begin
      and_in = 4'(k);
      #1;
      checks++;
      if (and_out !== (k == 15)) begin
        errors++;
        $display("FAIL R9: and_out actual %b expected %b", and_out, (k == 15));
      end
    end

    // random traffic, all four requesters
    tag = "R3";
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) if ($urandom_range(7) == 0) req_n[i] = ~req_n[i];
      en_n = ($urandom_range(15) == 0);
      and_in = 4'($urandom_range(15));
      if (c == 1000) rst_n = 1'b0;
      if (c == 1002) rst_n = 1'b1;
      tag = (c >= 1000 && c < 1006) ? "R10" : "R3";
      #1;
      checks++;
      if (and_out !== &and_in) begin
        errors++;
        $display("FAIL R9: and_out actual %b expected %b", and_out, &and_in);
      end
    end

    // random traffic with requester 3 tied high
    tag = "R7";
    req_n[3] = 1'b1;
    step(4);
    r3_tied_phase = 1'b1;
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) if ($urandom_range(7) == 0) req_n[i] = ~req_n[i];
      en_n = ($urandom_range(15) == 0);
    end
    r3_tied_phase = 1'b0;
    checks++;
    if (tied_grants != 0) begin
      errors++;
      $display("FAIL R7: tied-high grant count actual %0d expected 0", tied_grants);
    end
    step(2);
    finish_run();
  end
endmodule